// File: doc/BRIEF.md
# GPIO Bank with Write-One Set/Clear Control

This block drives and samples a bank of general-purpose pins. Each pin is an input or an output, chosen by a direction register. Every pin carries one flag bit. A small register bus changes the flags and the interrupt enables through separate write-one-to-set and write-one-to-clear addresses. Software can therefore change any group of bits in one write without touching the rest, and needs no read-modify-write.

For an output pin, the flag is the level driven onto the pad. For an input pin in level mode, the flag follows the synchronized pad level. For an input pin in edge mode, the flag is a sticky bit that a qualifying edge sets and software clears. Edge mode watches rising edges only or both edges, chosen per pin. A single interrupt line reports any flag whose enable bit is set. Input flags therefore raise hardware interrupts. Setting the flag of an output pin raises a software interrupt.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After a synchronous reset, the direction, flag, enable, sense and edge-select state are all zero, `pin_oe` is zero and `irq` is low.
- R2: Address 0 holds the direction bits (1 = output). A write updates `pin_oe` at the capturing clock edge, and a read returns the stored value.
- R3: A write to address 1 sets every flag bit written as 1 and leaves bits written as 0 unchanged. On output pins, `pin_out` shows the flag.
- R4: A write to address 2 clears every flag bit written as 1 and leaves bits written as 0 unchanged.
- R5: A read of address 1 or 2 returns the flag bits. A read of address 3 returns the synchronized pad levels, which pass through two flip-flop stages.
- R6: Addresses 4 and 5 set and clear the interrupt-enable bits with the same write-one rule. A read of either address returns the enables.
- R7: For an input pin with its address-6 sense bit at 0 (level mode), the flag equals the synchronized pad level. It updates three clock edges after a pad change, and writes to addresses 1 and 2 have no effect on it.
- R8: For an input pin with its sense bit at 1 (edge mode) and its address-7 bit at 0, a rising pad edge sets the flag three edges later. A falling edge leaves the flag as it is, and only a clear write to address 2 returns it to 0.
- R9: For an edge-mode input pin with its address-7 bit at 1, a falling pad edge also sets the flag.
- R10: When a detected edge and a clear write hit the same flag bit in the same cycle, that bit keeps its previous value.
- R11: `irq` is high one cycle after any flag bit and its enable bit are both 1, and it is low when no enable bit is set.
- R12: An output pin whose flag is set by software and whose enable bit is 1 raises `irq`.
- R13: `bus_rdata` is loaded one edge after a `bus_ren` cycle and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | NPIN | Registered read data |
| pin_in | input | NPIN | Pad input levels, asynchronous |
| pin_out | output | NPIN | Pad output levels (flag bits) |
| pin_oe | output | NPIN | Pad output enables (direction bits) |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two things can land on the same edge-mode flag bit in one cycle: the latch from a synchronized edge and a clear write from software. To force this, the bench drives a pad edge and then starts a clear write to that bit exactly two clock edges later, so both reach the flag register on the same edge. It does this once for a flag that was 0 and once for a flag that was 1. A later read must show both bits at their earlier values.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR   = 3'd0,
    RA_FSET  = 3'd1,
    RA_FCLR  = 3'd2,
    RA_PINS  = 3'd3,
    RA_MSET  = 3'd4,
    RA_MCLR  = 3'd5,
    RA_SENSE = 3'd6,
    RA_BOTH  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_sc_flags.sv
module gpio_sc_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, hw_set, any_set, nxt;

      always_comb begin
        rise    = lvl[i] & ~prev[i];
        fall    = ~lvl[i] & prev[i];
        hw_set  = ~dir[i] & sense[i] & (rise | (both[i] & fall));
        any_set = sw_set[i] | hw_set;
        if (!dir[i] && !sense[i])      nxt = lvl[i];
        else if (any_set && sw_clr[i]) nxt = flag[i];
        else if (any_set)              nxt = 1'b1;
        else if (sw_clr[i])            nxt = 1'b0;
        else                           nxt = flag[i];
      end

      always_ff @(posedge clk) begin
        if (rst) flag[i] <= 1'b0;
        else     flag[i] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
  import gpio_sc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_ren,
  input  logic [W-1:0]      flag,
  input  logic [W-1:0]      lvl,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      sense_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      sw_set,
  output logic [W-1:0]      sw_clr
);
  reg_addr_e    addr;
  logic [W-1:0] rd_mux;

  assign addr   = reg_addr_e'(bus_addr);
  assign sw_set = (bus_wen && addr == RA_FSET) ? bus_wdata : '0;
  assign sw_clr = (bus_wen && addr == RA_FCLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
    end else if (bus_wen) begin
      case (addr)
        RA_DIR:   dir_q   <= bus_wdata;
        RA_MSET:  mask_q  <= mask_q | bus_wdata;
        RA_MCLR:  mask_q  <= mask_q & ~bus_wdata;
        RA_SENSE: sense_q <= bus_wdata;
        RA_BOTH:  both_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_DIR:           rd_mux = dir_q;
      RA_FSET, RA_FCLR: rd_mux = flag;
      RA_PINS:          rd_mux = lvl;
      RA_MSET, RA_MCLR: rd_mux = mask_q;
      RA_SENSE:         rd_mux = sense_q;
      default:          rd_mux = both_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_sc_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic              bus_ren,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic [NPIN-1:0] lvl, flag_q, dir_q, mask_q, sense_q, both_q, sw_set, sw_clr;

  gpio_sc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(lvl)
  );

  gpio_sc_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .flag(flag_q), .lvl(lvl),
    .bus_rdata(bus_rdata), .dir_q(dir_q), .mask_q(mask_q),
    .sense_q(sense_q), .both_q(both_q), .sw_set(sw_set), .sw_clr(sw_clr)
  );

  gpio_sc_flags #(.W(NPIN)) u_flags (
    .clk(clk), .rst(rst), .lvl(lvl), .dir(dir_q), .sense(sense_q),
    .both(both_q), .sw_set(sw_set), .sw_clr(sw_clr), .flag(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_q & mask_q);
  end

  assign pin_out = flag_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      bus_addr,
  input logic            bus_wen,
  input logic [NPIN-1:0] bus_wdata,
  input logic            bus_ren,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] flag_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] sense_q
);
  logic [NPIN-1:0] set_w, clr_w, keep;
  assign set_w = (bus_wen && bus_addr == 3'd1) ? bus_wdata : '0;
  assign clr_w = (bus_wen && bus_addr == 3'd2) ? bus_wdata : '0;
  assign keep  = flag_q & sense_q & ~pin_oe & ~clr_w;

  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == 3'd0) |=> pin_oe == $past(bus_wdata));

  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_out & $past(set_w & pin_oe)) == $past(set_w & pin_oe));

  a_r4_clr_drives_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_out & $past(clr_w & pin_oe)) == '0);

  a_r8_edge_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_q & $past(keep)) == $past(keep));

  a_r11_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_ren |=> $stable(bus_rdata));
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .flag_q(flag_q), .mask_q(mask_q), .sense_q(sense_q)
);

// File: tb/gpio_setclr_bank_tb.sv
module gpio_setclr_bank_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   bus_addr = '0;
  logic         bus_wen = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_ren = 1'b0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [N-1:0] val; int req; } exp_t;
  exp_t sbq[$];
  bit pend = 1'b0;

  always #10 clk = ~clk;

  gpio_setclr_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input int req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data the cycle after capture
  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      if (sbq.size() == 0) chk(1'b0, 13, bus_rdata, '0);
      else begin
        e = sbq.pop_front();
        chk(bus_rdata === e.val, e.req, bus_rdata, e.val);
      end
    end
    pend = bus_ren;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    tick(1);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] exp, input int req);
    exp_t e;
    e.val = exp; e.req = req;
    sbq.push_back(e);
    bus_addr = a; bus_ren = 1'b1;
    tick(1);
    bus_ren = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk(pin_oe === '0, 1, pin_oe, '0);
    chk(irq === 1'b0, 1, {7'b0, irq}, '0);
    for (int a = 0; a < 8; a++) rd(3'(a), '0, 1);
    // R2: direction
    wr(3'd0, 8'hF0);
    chk(pin_oe === 8'hF0, 2, pin_oe, 8'hF0);
    rd(3'd0, 8'hF0, 2);
    // R3: write-one set, zeros untouched
    wr(3'd1, 8'h30);
    chk((pin_out & 8'hF0) === 8'h30, 3, pin_out & 8'hF0, 8'h30);
    wr(3'd1, 8'h00);
    chk((pin_out & 8'hF0) === 8'h30, 3, pin_out & 8'hF0, 8'h30);
    rd(3'd1, 8'h30, 3);
    // R4: write-one clear
    wr(3'd2, 8'h10);
    chk((pin_out & 8'hF0) === 8'h20, 4, pin_out & 8'hF0, 8'h20);
    rd(3'd2, 8'h20, 4);
    // R7 and R5: level mode follows pad, reads of flags and pads
    pin_in = 8'h05;
    tick(3);
    rd(3'd1, 8'h25, 7);
    rd(3'd3, 8'h05, 5);
    wr(3'd1, 8'h02);
    wr(3'd2, 8'h01);
    rd(3'd1, 8'h25, 7);
    // R6 and R11: enables and combined interrupt
    wr(3'd4, 8'h01);
    rd(3'd4, 8'h01, 6);
    chk(irq === 1'b1, 11, {7'b0, irq}, 8'h01);
    pin_in = 8'h00;
    tick(4);
    chk(irq === 1'b0, 11, {7'b0, irq}, 8'h00);
    // R12: software interrupt from an output pin
    wr(3'd4, 8'h20);
    tick(1);
    chk(irq === 1'b1, 12, {7'b0, irq}, 8'h01);
    wr(3'd5, 8'h20);
    rd(3'd5, 8'h01, 6);
    chk(irq === 1'b0, 12, {7'b0, irq}, 8'h00);
    // R8: rising-edge mode on the low nibble
    wr(3'd6, 8'h0F);
    pin_in = 8'h02;
    tick(3);
    rd(3'd1, 8'h22, 8);
    pin_in = 8'h00;
    tick(3);
    rd(3'd1, 8'h22, 8);
    wr(3'd2, 8'h02);
    rd(3'd1, 8'h20, 8);
    // R9: both-edge mode on bit 2
    wr(3'd7, 8'h04);
    pin_in = 8'h04;
    tick(3);
    rd(3'd1, 8'h24, 9);
    wr(3'd2, 8'h04);
    pin_in = 8'h00;
    tick(3);
    rd(3'd1, 8'h24, 9);
    rd(3'd7, 8'h04, 9);
    rd(3'd6, 8'h0F, 8);
    // R10: edge latch and clear write on the same edge
    pin_in = 8'h0C;
    tick(2);
    wr(3'd2, 8'h0C);
    rd(3'd1, 8'h24, 10);
    wr(3'd2, 8'h04);
    rd(3'd1, 8'h20, 10);
    // R13: read data holds between reads
    tick(3);
    chk(bus_rdata === 8'h20, 13, bus_rdata, 8'h20);
    tick(2);
    chk(sbq.size() == 0, 13, 8'(sbq.size()), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule